// File: doc/BRIEF.md
# Hidden I/O Index/Data PCI Target

This block is a PCI target with no configuration space. It answers only I/O reads and I/O writes that fall inside one 4-byte window. The window sits at 0178h when the base-select strap is high and at 0078h when the strap is low. Inside the window, the byte at window offset 0 is the index port and the byte at window offset 2 is the data port. Writing the index port selects one of 256 internal 8-bit registers. Accesses to the data port then read or write the selected register. A plain register file stands in for the functions that would sit behind those registers.

Register D1h carries the unlock bit in bit 5. While that bit is 0, data-port accesses to any register other than D1h are blocked: blocked writes are discarded and blocked reads return FFh. The bus handshake still completes as usual, and DEVSEL# is still asserted. Register F7h holds the upper byte of a 16-bit field at F6h. Its bit 7 reads as 1 whenever the strap is low.

The cycle controller has eight states. IDLE moves to START_S on a hit, or to BUS_BUSY when FRAME# falls without a hit. BUS_BUSY returns to IDLE once FRAME# and IRDY# are both high. START_S moves to HITCMD1, where DEVSEL# is driven low. HITCMD1 moves to HITCMD2, where TRDY# is also driven low. HITCMD2 moves to TURN_AR on IRDY# low, and otherwise to HITCMD3, which waits for IRDY# low. TURN_AR drives DEVSEL# and TRDY# high for one clock and moves to OVER_S. OVER_S releases both signals and returns to IDLE once FRAME# and IRDY# are both high.

Top module: `hidden_io_slave`

## Requirements
- R1: After reset, DEVSEL#, TRDY# and AD are not driven (devsel_oe, trdy_oe and ad_oe are 0), the index is 00h, and every register is 00h, so the block starts locked.
- R2: A cycle whose command is a configuration read (1010b) or a configuration write (1011b) is never claimed. Neither is any cycle outside the window, or any command other than I/O read (0010b) or I/O write (0011b). For such a cycle, devsel_oe stays 0 until the bus is idle again.
- R3: With strap_hi = 1 the window is 0178h–017Bh. With strap_hi = 0 it is 0078h–007Bh. The other pair is not claimed.
- R4: Counting the clock edge that samples FRAME# low as edge 0, DEVSEL# goes low after edge 1 and TRDY# goes low after edge 2. After the edge where TRDY# and IRDY# are both low, both signals are driven high for one clock, and then they are released.
- R5: An I/O write to window offset 0 with C/BE#[0] low loads AD[7:0] into the index. An I/O read of the window returns the index on AD[7:0].
- R6: While unlocked, an I/O write to window offset 2 with C/BE#[2] low stores AD[23:16] into the register at the index. An I/O read of offset 2 returns that register on AD[23:16].
- R7: While bit 5 of register D1h is 0, a data-port write to any other index is discarded and a data-port read returns FFh on AD[23:16]. The access is still claimed and completed.
- R8: Register D1h can be read and written through the data port whether the block is locked or unlocked.
- R9: When strap_hi = 0, bit 7 of register F7h reads as 1 regardless of its stored value. When strap_hi = 1, bit 7 reads the stored value.
- R10: A data-port write with C/BE#[2] high leaves the register unchanged.
- R11: While TRDY# is low and IRDY# is high, TRDY# and DEVSEL# stay low and no transfer takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| strap_hi | input | 1 | Base select: 1 for 0178h, 0 for 0078h |
| frame_n | input | 1 | FRAME# from the initiator |
| irdy_n | input | 1 | IRDY# from the initiator |
| cbe_n | input | 4 | Command in the address phase, byte enables in the data phase |
| ad_in | input | 32 | Address/data bus as seen by the block |
| ad_out | output | 32 | Read data driven onto AD |
| ad_oe | output | 1 | Enable for driving AD |
| devsel_n | output | 1 | DEVSEL# value |
| devsel_oe | output | 1 | Enable for driving DEVSEL# |
| trdy_n | output | 1 | TRDY# value |
| trdy_oe | output | 1 | Enable for driving TRDY# |

## Verification
The lock decision and the register write can fall in the same transfer clock. This happens when a data-port write targets D1h itself, so the unlock bit changes in the very write that the current lock state is gating. The bench provokes it by unlocking and later relocking through D1h. It then judges the outcome through later data-port reads: a write to another register made while locked must read back unchanged after unlocking, and the relocking write must itself land. An index write and a data handshake that stretches with wait states are also run back to back, to show that a delayed IRDY# does not shift the transfer clock.

// File: rtl/hio_pkg.sv
package hio_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BUS_BUSY,
        ST_START_S,
        ST_HITCMD1,
        ST_HITCMD2,
        ST_HITCMD3,
        ST_TURN_AR,
        ST_OVER_S
    } hio_state_e;

    localparam logic [3:0] CMD_IO_RD = 4'b0010;
    localparam logic [3:0] CMD_IO_WR = 4'b0011;
    localparam logic [1:0] LANE_IDX  = 2'd0;
    localparam logic [1:0] LANE_DAT  = 2'd2;
endpackage

// File: rtl/hio_decode.sv
module hio_decode
    import hio_pkg::*;
#(
    parameter int          AW      = 32,
    parameter logic [15:0] BASE_HI = 16'h0178,
    parameter logic [15:0] BASE_LO = 16'h0078
) (
    input  logic [AW-1:0] ad,
    input  logic [3:0]    cmd_n,
    input  logic          strap_hi,
    output logic          hit,
    output logic          is_wr,
    output logic [1:0]    lane
);
    logic [AW-1:0] base;

    always_comb begin
        base  = strap_hi ? AW'(BASE_HI) : AW'(BASE_LO);
        is_wr = (cmd_n == CMD_IO_WR);
        lane  = ad[1:0];
        hit   = ((cmd_n == CMD_IO_RD) || (cmd_n == CMD_IO_WR)) &&
                (ad[AW-1:2] == base[AW-1:2]);
    end
endmodule

// File: rtl/hio_fsm.sv
module hio_fsm
    import hio_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_n,
    input  logic       irdy_n,
    input  logic       hit,
    input  logic       is_wr,
    input  logic [1:0] lane_in,
    output hio_state_e state,
    output logic       wr_q,
    output logic [1:0] lane_q,
    output logic       commit,
    output logic       devsel_n,
    output logic       devsel_oe,
    output logic       trdy_n,
    output logic       trdy_oe,
    output logic       ad_oe
);
    hio_state_e nxt;
    logic       nocycle;

    assign nocycle = frame_n && irdy_n;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:     if (!frame_n) nxt = hit ? ST_START_S : ST_BUS_BUSY;
            ST_BUS_BUSY: if (nocycle) nxt = ST_IDLE;
            ST_START_S:  nxt = ST_HITCMD1;
            ST_HITCMD1:  nxt = ST_HITCMD2;
            ST_HITCMD2:  nxt = irdy_n ? ST_HITCMD3 : ST_TURN_AR;
            ST_HITCMD3:  if (!irdy_n) nxt = ST_TURN_AR;
            ST_TURN_AR:  nxt = ST_OVER_S;
            ST_OVER_S:   if (nocycle) nxt = ST_IDLE;
            default:     nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            wr_q   <= 1'b0;
            lane_q <= 2'd0;
        end else begin
            state <= nxt;
            if (state == ST_IDLE && !frame_n) begin
                wr_q   <= is_wr;
                lane_q <= lane_in;
            end
        end
    end

    always_comb begin
        logic claim;
        claim     = (state == ST_HITCMD1) || (state == ST_HITCMD2) || (state == ST_HITCMD3);
        devsel_oe = claim || (state == ST_TURN_AR);
        trdy_oe   = devsel_oe;
        devsel_n  = !claim;
        trdy_n    = !((state == ST_HITCMD2) || (state == ST_HITCMD3));
        ad_oe     = claim && !wr_q;
        commit    = !trdy_n && !irdy_n;
    end

    // R4: TRDY# falls only after DEVSEL# was already low
    p_trdy_after_devsel_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(trdy_n) |-> $past(devsel_oe && !devsel_n));
    // R4: transfer is followed by one driven-high clock
    p_turnaround_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!trdy_n && !irdy_n) |=> (devsel_oe && devsel_n && trdy_n));
    // R4: driven-high clock is followed by release
    p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (devsel_oe && devsel_n) |=> !devsel_oe);
    // R11: wait states keep TRDY# low
    p_wait_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!trdy_n && irdy_n) |=> (!trdy_n && !devsel_n));
endmodule

// File: rtl/hio_regbank.sv
module hio_regbank
    import hio_pkg::*;
#(
    parameter int               OFS_W     = 8,
    parameter logic [OFS_W-1:0] LOCK_OFS  = 8'hD1,
    parameter int               LOCK_BIT  = 5,
    parameter logic [OFS_W-1:0] STRAP_OFS = 8'hF7,
    parameter int               STRAP_BIT = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strap_hi,
    input  logic             commit,
    input  logic             wr,
    input  logic [1:0]       lane,
    input  logic             be_idx_n,
    input  logic             be_dat_n,
    input  logic [OFS_W-1:0] wd_idx,
    input  logic [7:0]       wd_dat,
    output logic [OFS_W-1:0] index_q,
    output logic [7:0]       rd_dat
);
    localparam int DEPTH = 1 << OFS_W;

    logic [7:0] mem [DEPTH];
    logic [7:0] cur_val;
    logic       unlocked;
    logic       blocked;
    logic       wr_idx, wr_dat;

    assign cur_val  = mem[index_q];
    assign unlocked = mem[LOCK_OFS][LOCK_BIT];
    assign blocked  = !unlocked && (index_q != LOCK_OFS);
    assign wr_idx   = commit && wr && (lane == LANE_IDX) && !be_idx_n;
    assign wr_dat   = commit && wr && (lane == LANE_DAT) && !be_dat_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            index_q <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
        end else begin
            if (wr_idx) index_q <= wd_idx;
            if (wr_dat && !blocked) mem[index_q] <= wd_dat;
        end
    end

    always_comb begin
        rd_dat = cur_val;
        if (index_q == STRAP_OFS && !strap_hi) rd_dat[STRAP_BIT] = 1'b1;
        if (blocked) rd_dat = 8'hFF;
    end

    // R7: a locked data write to another register leaves it untouched
    p_locked_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_dat && blocked) |=> $stable(cur_val));
    // R8: the lock register always accepts a data write
    p_lock_reach_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_dat && index_q == LOCK_OFS) |=> (unlocked == $past(wd_dat[LOCK_BIT])));
endmodule

// File: rtl/hidden_io_slave.sv
module hidden_io_slave
    import hio_pkg::*;
#(
    parameter int          AW      = 32,
    parameter logic [15:0] BASE_HI = 16'h0178,
    parameter logic [15:0] BASE_LO = 16'h0078
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          strap_hi,
    input  logic          frame_n,
    input  logic          irdy_n,
    input  logic [3:0]    cbe_n,
    input  logic [AW-1:0] ad_in,
    output logic [AW-1:0] ad_out,
    output logic          ad_oe,
    output logic          devsel_n,
    output logic          devsel_oe,
    output logic          trdy_n,
    output logic          trdy_oe
);
    logic       hit, is_wr, wr_q, commit;
    logic [1:0] lane, lane_q;
    logic [7:0] index_q, rd_dat;
    hio_state_e state;

    hio_decode #(.AW(AW), .BASE_HI(BASE_HI), .BASE_LO(BASE_LO)) u_dec (
        .ad(ad_in), .cmd_n(cbe_n), .strap_hi(strap_hi),
        .hit(hit), .is_wr(is_wr), .lane(lane)
    );

    hio_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
        .hit(hit), .is_wr(is_wr), .lane_in(lane), .state(state),
        .wr_q(wr_q), .lane_q(lane_q), .commit(commit),
        .devsel_n(devsel_n), .devsel_oe(devsel_oe),
        .trdy_n(trdy_n), .trdy_oe(trdy_oe), .ad_oe(ad_oe)
    );

    hio_regbank u_regs (
        .clk(clk), .rst_n(rst_n), .strap_hi(strap_hi), .commit(commit),
        .wr(wr_q), .lane(lane_q), .be_idx_n(cbe_n[0]), .be_dat_n(cbe_n[2]),
        .wd_idx(ad_in[7:0]), .wd_dat(ad_in[23:16]),
        .index_q(index_q), .rd_dat(rd_dat)
    );

    always_comb begin
        ad_out = '0;
        if (ad_oe) begin
            ad_out[7:0]   = index_q;
            ad_out[23:16] = rd_dat;
        end
    end

    // R2: configuration commands never leave IDLE toward a claim
    p_cfg_unclaimed_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !frame_n && cbe_n[3:1] == 3'b101) |=> (state == ST_BUS_BUSY));
endmodule

// File: tb/hidden_io_slave_tb_top.sv
module hidden_io_slave_tb_top;
    localparam int CLK_NS = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strap_hi = 1'b1;
    logic        frame_n = 1'b1;
    logic        irdy_n = 1'b1;
    logic [3:0]  cbe_n = 4'hF;
    logic [31:0] ad_in = '0;
    logic [31:0] ad_out;
    logic        ad_oe, devsel_n, devsel_oe, trdy_n, trdy_oe;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_val [$];
    logic [31:0] exp_msk [$];
    string       exp_tag [$];

    always #(CLK_NS/2) clk = ~clk;

    hidden_io_slave dut_i (
        .clk(clk), .rst_n(rst_n), .strap_hi(strap_hi), .frame_n(frame_n),
        .irdy_n(irdy_n), .cbe_n(cbe_n), .ad_in(ad_in), .ad_out(ad_out),
        .ad_oe(ad_oe), .devsel_n(devsel_n), .devsel_oe(devsel_oe),
        .trdy_n(trdy_n), .trdy_oe(trdy_oe)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // monitor: pops expected read data at every read transfer
    initial begin
        forever begin
            @(negedge clk); #1;
            if (ad_oe && !trdy_n && !irdy_n) begin
                if (exp_val.size() == 0) begin
                    check(1'b0, "read with no expectation", ad_out, 32'h0);
                end else begin
                    logic [31:0] v, m;
                    string t;
                    v = exp_val.pop_front(); m = exp_msk.pop_front(); t = exp_tag.pop_front();
                    check((ad_out & m) == v, t, ad_out & m, v);
                end
            end
        end
    end

    // one claimed I/O cycle, checking the R4 handshake along the way
    task automatic bus_op(input logic [31:0] addr, input bit wr, input logic [31:0] wd,
                          input logic [3:0] ben, input int waits);
        @(negedge clk);
        frame_n = 1'b0; irdy_n = 1'b1; ad_in = addr; cbe_n = wr ? 4'b0011 : 4'b0010;
        @(negedge clk);
        check(!devsel_oe, "R4 no claim in clock after address", {31'b0, devsel_oe}, 32'h0);
        cbe_n = ben; ad_in = wr ? wd : 32'h0;
        if (waits == 0) begin frame_n = 1'b1; irdy_n = 1'b0; end
        @(negedge clk);
        check(devsel_oe && !devsel_n && trdy_n, "R4 DEVSEL# low, TRDY# high",
              {30'b0, devsel_n, trdy_n}, 32'h1);
        @(negedge clk);
        check(!trdy_n && !devsel_n, "R4 TRDY# low one clock later", {31'b0, trdy_n}, 32'h0);
        for (int i = 0; i < waits; i++) begin
            @(negedge clk);
            check(!trdy_n && !devsel_n, "R11 TRDY# held during wait", {31'b0, trdy_n}, 32'h0);
        end
        if (waits != 0) begin frame_n = 1'b1; irdy_n = 1'b0; end
        @(negedge clk);
        check(devsel_oe && trdy_oe && devsel_n && trdy_n, "R4 turnaround driven high",
              {28'b0, devsel_oe, trdy_oe, devsel_n, trdy_n}, 32'hF);
        irdy_n = 1'b1; ad_in = '0; cbe_n = 4'hF;
        @(negedge clk);
        check(!devsel_oe && !trdy_oe, "R4 released after turnaround",
              {30'b0, devsel_oe, trdy_oe}, 32'h0);
    endtask

    task automatic wr_index(input logic [31:0] base, input logic [7:0] v);
        bus_op(base, 1'b1, {24'h0, v}, 4'b1110, 0);
    endtask

    task automatic wr_data(input logic [31:0] base, input logic [7:0] v, input logic [3:0] ben);
        bus_op(base + 2, 1'b1, {8'h0, v, 16'h0}, ben, 0);
    endtask

    task automatic rd_index(input logic [31:0] base, input logic [7:0] e, input string tag);
        exp_val.push_back({24'h0, e}); exp_msk.push_back(32'h0000_00FF); exp_tag.push_back(tag);
        bus_op(base, 1'b0, 32'h0, 4'b1110, 0);
    endtask

    task automatic rd_data(input logic [31:0] base, input logic [7:0] e, input int waits, input string tag);
        exp_val.push_back({8'h0, e, 16'h0}); exp_msk.push_back(32'h00FF_0000); exp_tag.push_back(tag);
        bus_op(base + 2, 1'b0, 32'h0, 4'b1011, waits);
    endtask

    // cycle that must not be claimed
    task automatic no_claim(input logic [31:0] addr, input logic [3:0] cmd, input string tag);
        bit seen;
        seen = 1'b0;
        @(negedge clk);
        frame_n = 1'b0; irdy_n = 1'b1; ad_in = addr; cbe_n = cmd;
        @(negedge clk);
        seen |= devsel_oe;
        frame_n = 1'b1; irdy_n = 1'b0; cbe_n = 4'h0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            seen |= devsel_oe | trdy_oe;
        end
        irdy_n = 1'b1; cbe_n = 4'hF; ad_in = '0;
        @(negedge clk); @(negedge clk);
        seen |= devsel_oe;
        check(!seen, tag, {31'b0, seen}, 32'h0);
    endtask

    initial begin
        #(CLK_NS * 100000);
        check(1'b0, "watchdog expired", 32'h0, 32'h1);
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!devsel_oe && !trdy_oe && !ad_oe, "R1 outputs released in reset",
              {29'b0, devsel_oe, trdy_oe, ad_oe}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!devsel_oe && !trdy_oe && !ad_oe, "R1 outputs released after reset",
              {29'b0, devsel_oe, trdy_oe, ad_oe}, 32'h0);

        rd_index(32'h178, 8'h00, "R1 index resets to 00");
        rd_data(32'h178, 8'hFF, 0, "R1 locked at reset (reg 00 blocked)");

        no_claim(32'h178, 4'b1010, "R2 config read not claimed");
        no_claim(32'h178, 4'b1011, "R2 config write not claimed");
        no_claim(32'h17C, 4'b0010, "R2 outside window not claimed");
        no_claim(32'h178, 4'b0110, "R2 memory read not claimed");
        no_claim(32'h078, 4'b0010, "R3 low pair unclaimed with strap high");

        wr_index(32'h178, 8'h10);
        rd_index(32'h178, 8'h10, "R5 index readback");
        wr_data(32'h178, 8'h5A, 4'b1011);
        rd_data(32'h178, 8'hFF, 0, "R7 locked read returns FF");

        wr_index(32'h178, 8'hD1);
        rd_data(32'h178, 8'h00, 0, "R8 lock reg readable while locked");
        wr_data(32'h178, 8'h20, 4'b1011);
        rd_data(32'h178, 8'h20, 0, "R8 lock reg written while locked");

        wr_index(32'h178, 8'h10);
        rd_data(32'h178, 8'h00, 0, "R7 locked write was discarded");
        wr_data(32'h178, 8'h5A, 4'b1011);
        rd_data(32'h178, 8'h5A, 0, "R6 unlocked write/read");
        wr_data(32'h178, 8'hC3, 4'b1111);
        rd_data(32'h178, 8'h5A, 2, "R10 disabled lane ignored, R11 wait read");
        wr_index(32'h178, 8'h33);
        wr_data(32'h178, 8'hC3, 4'b1011);
        rd_data(32'h178, 8'hC3, 1, "R6 second register, R11 wait");

        wr_index(32'h178, 8'hF7);
        rd_data(32'h178, 8'h00, 0, "R9 F7 bit7 clear with strap high");
        strap_hi = 1'b0;
        @(negedge clk);
        rd_data(32'h078, 8'h80, 0, "R9 F7 bit7 set with strap low, R3 low pair");
        wr_data(32'h078, 8'h01, 4'b1011);
        rd_data(32'h078, 8'h81, 0, "R9 stored bits kept with strap low");
        no_claim(32'h178, 4'b0010, "R3 high pair unclaimed with strap low");
        strap_hi = 1'b1;
        @(negedge clk);
        rd_data(32'h178, 8'h01, 0, "R9 stored bit7 returns with strap high");

        wr_index(32'h178, 8'hD1);
        wr_data(32'h178, 8'h00, 4'b1011);
        rd_data(32'h178, 8'h00, 0, "R8 relock write landed");
        wr_index(32'h178, 8'h33);
        rd_data(32'h178, 8'hFF, 0, "R7 relocked read returns FF");

        repeat (4) @(negedge clk);
        check(exp_val.size() == 0, "R6 all expected reads observed", exp_val.size(), 32'h0);
        finish_up();
    end
endmodule